// File: doc/BRIEF.md
# Switching Frequency Source Supervisor

This block is the digital supervisor beside a buck controller's oscillator. It picks the clock source the switching stage runs from: the internal fixed oscillator, a frequency programmed by an external resistor, or an external synchronization clock. It also decides whether spread-spectrum dithering is allowed. The analog oscillator, the resistor measurement and the sync-clock detector are not part of it. They hand the block digitized flags, and the block returns a range select, a source select and a dither enable.

Pin straps are sampled on the first clock after the supply leaves undervoltage lockout. They are then held until the supply drops back into lockout. Lockout also clears every latch and timer asynchronously. A resistor-set frequency is adopted only after a qualification window. The window is counted in system clocks and runs while soft-start is done, the output is in regulation and the controller is out of standby. Any event that could make the resistor reading untrustworthy restarts the window.

Top module: `freq_mode_ctrl`

## Requirements
- R1: The range strap `oscStrap` is sampled on the first rising clock edge after `supplyGood` goes high (1 = high range, 0 = low range). `rangeHigh` then holds that value, whatever the strap does later, until `supplyGood` falls.
- R2: While `rtValid` is low, which covers a reading flagged by `rtOpen` or `rtShort`, `srcSel` never selects the resistor source. `srcSel` encodes 0 = internal oscillator, 1 = resistor-set and 2 = external sync. After `rtValid` returns, the resistor source is taken again after a fresh qualification window.
- R3: If `rtShort` is high at the capture edge, `srcSel` stays off the resistor source until the next lockout, even once `rtValid` rises. If `rtOpen` is high at capture instead, a resistor that becomes valid later can still be adopted.
- R4: With the strap captured and `rtValid`, `ssDone` and `inReg` high and `standby` and `zeroCross` low, `srcSel` becomes 1 after exactly QUAL_CYCLES rising edges of that condition and not one edge sooner.
- R5: While `syncPresent` is high and the straps are captured, `srcSel` is 2, overriding a qualified resistor. Sync presence does not restart the qualification window.
- R6: `ditherEn` is high only when the straps are captured, dither is not locked, `ditherLive` (the pin is above ground) is high and `syncPresent` is low. Sync forces it low.
- R7: If `ditherRail` is high at the capture edge, `ditherEn` stays low until the next lockout, regardless of `ditherLive`.
- R8: A `zeroCross` pulse seen at a clock edge restarts qualification. From the next cycle `srcSel` is not 1 until QUAL_CYCLES further qualifying edges have occurred.
- R9: While `standby` is high, `srcSel` is not 1. After standby exit a full qualification window is required before `srcSel` returns to 1.
- R10: While `supplyGood` is low, `srcSel` is 0, `ditherEn` is 0 and `rangeHigh` is 0, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| supplyGood | input | 1 | High when the supply is above the lockout threshold; low resets asynchronously |
| oscStrap | input | 1 | Range strap level |
| rtOpen | input | 1 | Resistor reading above the upper window |
| rtShort | input | 1 | Resistor reading below the lower window |
| rtValid | input | 1 | Resistor reading inside the window |
| ditherRail | input | 1 | Dither pin tied to the rail |
| ditherLive | input | 1 | Dither pin above ground |
| ssDone | input | 1 | Soft-start complete |
| inReg | input | 1 | Output in regulation |
| syncPresent | input | 1 | External sync clock detected |
| standby | input | 1 | Controller in low-current standby |
| zeroCross | input | 1 | Inductor current zero-crossing pulse |
| rangeHigh | output | 1 | Latched range select, 1 = high range |
| srcSel | output | 2 | Frequency source: 0 internal, 1 resistor, 2 sync |
| ditherEn | output | 1 | Dither modulation enable |

## Verification
A wrong qualification count shows at `srcSel` as a move to the resistor source one or more cycles early or late. It is visible on the exact edge where QUAL_CYCLES qualifying edges complete. A missed restart leaves `srcSel` at 1 on the cycle right after a zero-crossing or a loss of the valid flag. A bad strap latch shows up as soon as the strap pin is moved after capture, or after a lockout cycle with the opposite strap, through `rangeHigh`, a resistor source that should stay locked out, or a dither enable that should stay off.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_RT   = 2'd1,
    SRC_SYNC = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic captureNow;
    logic qualStep;
    logic qualClear;
  } fmcStrobe_t;
endpackage

// File: rtl/fmc_ctrl.sv
module fmc_ctrl
  import fmc_pkg::*;
(
  input  logic       clk,
  input  logic       supplyGood,
  input  logic       rtValid,
  input  logic       ssDone,
  input  logic       inReg,
  input  logic       standby,
  input  logic       zeroCross,
  input  logic       rtLocked,
  input  logic       qualDone,
  output fmcStrobe_t strobe,
  output logic       captured
);
  logic eligible;

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) captured <= 1'b0;
    else             captured <= 1'b1;
  end

  // qualifying condition for one edge of the resistor window
  always_comb begin
    eligible = captured && !rtLocked && rtValid && ssDone && inReg
               && !standby && !zeroCross;
    strobe.captureNow = !captured;
    strobe.qualStep   = eligible && !qualDone;
    strobe.qualClear  = !eligible;
  end
endmodule

// File: rtl/fmc_dp.sv
module fmc_dp
  import fmc_pkg::*;
#(
  parameter int QUAL_CYCLES = 4000
) (
  input  logic       clk,
  input  logic       supplyGood,
  input  fmcStrobe_t strobe,
  input  logic       captured,
  input  logic       oscStrap,
  input  logic       rtShort,
  input  logic       rtValid,
  input  logic       ditherRail,
  input  logic       ditherLive,
  input  logic       syncPresent,
  input  logic       standby,
  output logic       rtLocked,
  output logic       qualDone,
  output logic       rangeHigh,
  output srcSel_e    srcSel,
  output logic       ditherEn
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] QUAL_LAST = CW'(QUAL_CYCLES);

  logic          rangeReg;
  logic          dithLocked;
  logic [CW-1:0] qualCnt;

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) begin
      rangeReg   <= 1'b0;
      rtLocked   <= 1'b0;
      dithLocked <= 1'b0;
    end else if (strobe.captureNow) begin
      rangeReg   <= oscStrap;
      rtLocked   <= rtShort;
      dithLocked <= ditherRail;
    end
  end

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood)          qualCnt <= '0;
    else if (strobe.qualClear) qualCnt <= '0;
    else if (strobe.qualStep)  qualCnt <= qualCnt + 1'b1;
  end

  assign qualDone  = (qualCnt == QUAL_LAST);
  assign rangeHigh = rangeReg;

  always_comb begin
    srcSel = SRC_INT;
    if (captured) begin
      if (syncPresent)                       srcSel = SRC_SYNC;
      else if (qualDone && rtValid && !standby) srcSel = SRC_RT;
    end
    ditherEn = captured && !dithLocked && ditherLive && !syncPresent;
  end
endmodule

// File: rtl/freq_mode_ctrl.sv
module freq_mode_ctrl
  import fmc_pkg::*;
#(
  parameter int QUAL_CYCLES = 4000
) (
  input  logic       clk,
  input  logic       supplyGood,
  input  logic       oscStrap,
  input  logic       rtOpen,
  input  logic       rtShort,
  input  logic       rtValid,
  input  logic       ditherRail,
  input  logic       ditherLive,
  input  logic       ssDone,
  input  logic       inReg,
  input  logic       syncPresent,
  input  logic       standby,
  input  logic       zeroCross,
  output logic       rangeHigh,
  output logic [1:0] srcSel,
  output logic       ditherEn
);
  fmcStrobe_t strobe;
  logic       captured;
  logic       rtLocked;
  logic       qualDone;
  srcSel_e    srcEnum;
  logic       openSeen;

  // an open reading needs no action beyond not being valid
  assign openSeen = rtOpen;

  fmc_ctrl u_ctrl (
    .clk(clk), .supplyGood(supplyGood), .rtValid(rtValid && !openSeen),
    .ssDone(ssDone), .inReg(inReg), .standby(standby),
    .zeroCross(zeroCross), .rtLocked(rtLocked), .qualDone(qualDone),
    .strobe(strobe), .captured(captured)
  );

  fmc_dp #(.QUAL_CYCLES(QUAL_CYCLES)) u_dp (
    .clk(clk), .supplyGood(supplyGood), .strobe(strobe), .captured(captured),
    .oscStrap(oscStrap), .rtShort(rtShort), .rtValid(rtValid && !openSeen),
    .ditherRail(ditherRail), .ditherLive(ditherLive),
    .syncPresent(syncPresent), .standby(standby),
    .rtLocked(rtLocked), .qualDone(qualDone), .rangeHigh(rangeHigh),
    .srcSel(srcEnum), .ditherEn(ditherEn)
  );

  assign srcSel = srcEnum;
endmodule

// File: rtl/fmc_checker.sv
module fmc_checker (
  input logic       clk,
  input logic       supplyGood,
  input logic       captured,
  input logic       syncPresent,
  input logic       standby,
  input logic       zeroCross,
  input logic       rtValid,
  input logic       rangeHigh,
  input logic [1:0] srcSel,
  input logic       ditherEn
);
  // R5
  sync_over_chk: assert property (@(posedge clk) disable iff (!supplyGood)
    (captured && syncPresent) |-> (srcSel == 2'd2));
  // R6
  sync_dither_chk: assert property (@(posedge clk) disable iff (!supplyGood)
    syncPresent |-> !ditherEn);
  // R1
  range_hold_chk: assert property (@(posedge clk) disable iff (!supplyGood)
    (captured && $past(captured)) |-> $stable(rangeHigh));
  // R9
  standby_chk: assert property (@(posedge clk) disable iff (!supplyGood)
    standby |-> (srcSel != 2'd1));
  // R8
  zc_restart_chk: assert property (@(posedge clk) disable iff (!supplyGood)
    zeroCross |=> (srcSel != 2'd1));
  // R2
  invalid_rt_chk: assert property (@(posedge clk) disable iff (!supplyGood)
    !rtValid |-> (srcSel != 2'd1));
  // R10
  lockout_chk: assert property (@(posedge clk)
    !supplyGood |-> (srcSel == 2'd0 && !ditherEn && !rangeHigh));
endmodule

bind freq_mode_ctrl fmc_checker u_fmc_checker (
  .clk(clk), .supplyGood(supplyGood), .captured(captured),
  .syncPresent(syncPresent), .standby(standby), .zeroCross(zeroCross),
  .rtValid(rtValid), .rangeHigh(rangeHigh), .srcSel(srcSel),
  .ditherEn(ditherEn)
);

// File: tb/test_freq_mode_ctrl.sv
`timescale 1ns/1ps
module test_freq_mode_ctrl;
  localparam int QUAL = 20;

  logic clk = 1'b0;
  logic supplyGood, oscStrap, rtOpen, rtShort, rtValid, ditherRail, ditherLive;
  logic ssDone, inReg, syncPresent, standby, zeroCross;
  logic rangeHigh, ditherEn;
  logic [1:0] srcSel;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  freq_mode_ctrl #(.QUAL_CYCLES(QUAL)) i_freq_mode_ctrl (
    .clk(clk), .supplyGood(supplyGood), .oscStrap(oscStrap), .rtOpen(rtOpen),
    .rtShort(rtShort), .rtValid(rtValid), .ditherRail(ditherRail),
    .ditherLive(ditherLive), .ssDone(ssDone), .inReg(inReg),
    .syncPresent(syncPresent), .standby(standby), .zeroCross(zeroCross),
    .rangeHigh(rangeHigh), .srcSel(srcSel), .ditherEn(ditherEn)
  );

  // {syncPresent, ditherLive, expected srcSel, expected ditherEn}
  localparam logic [4:0] VEC [4] = '{
    {1'b0, 1'b1, 2'd1, 1'b1},
    {1'b1, 1'b1, 2'd2, 1'b0},
    {1'b1, 1'b0, 2'd2, 1'b0},
    {1'b0, 1'b0, 2'd1, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    supplyGood = 1'b1;
    oscStrap = 1'b1; rtOpen = 1'b1; rtShort = 1'b0; rtValid = 1'b0;
    ditherRail = 1'b0; ditherLive = 1'b1; ssDone = 1'b1; inReg = 1'b1;
    syncPresent = 1'b1; standby = 1'b0; zeroCross = 1'b0;
    #1 supplyGood = 1'b0;
    step(3);
    // R10 outputs held off during lockout
    chk("R10 src in lockout", srcSel, 0);
    chk("R10 dither in lockout", ditherEn, 0);
    chk("R10 range in lockout", rangeHigh, 0);

    syncPresent = 1'b0; ditherLive = 1'b0; ssDone = 1'b0; inReg = 1'b0;
    supplyGood = 1'b1;
    step(1);
    oscStrap = 1'b0;
    step(2);
    chk("R1 range latched high", rangeHigh, 1);

    // R3 open at capture: a later valid resistor is adopted; R4 window length
    rtOpen = 1'b0; rtValid = 1'b1; ssDone = 1'b1; inReg = 1'b1;
    step(QUAL - 1);
    chk("R4 one edge early", srcSel, 0);
    step(1);
    chk("R4 qualified", srcSel, 1);

    // R5 R6 table of sync and dither-pin patterns
    for (int i = 0; i < 4; i++) begin
      syncPresent = VEC[i][4];
      ditherLive  = VEC[i][3];
      step(1);
      chk($sformatf("R5 src vector %0d", i), srcSel, int'(VEC[i][2:1]));
      chk($sformatf("R6 dither vector %0d", i), ditherEn, int'(VEC[i][0]));
    end

    // R8 zero-crossing restart
    zeroCross = 1'b1;
    step(1);
    zeroCross = 1'b0;
    chk("R8 after zero-cross", srcSel, 0);
    step(QUAL - 1);
    chk("R8 window not complete", srcSel, 0);
    step(1);
    chk("R8 requalified", srcSel, 1);

    // R9 standby ignores resistor, then full window
    standby = 1'b1;
    step(1);
    chk("R9 in standby", srcSel, 0);
    step(5);
    standby = 1'b0;
    step(QUAL - 1);
    chk("R9 after exit early", srcSel, 0);
    step(1);
    chk("R9 after exit qualified", srcSel, 1);

    // R2 short reading uses internal oscillator
    rtValid = 1'b0; rtShort = 1'b1;
    step(1);
    chk("R2 short reading", srcSel, 0);
    rtShort = 1'b0; rtOpen = 1'b1;
    step(1);
    chk("R2 open reading", srcSel, 0);
    rtOpen = 1'b0; rtValid = 1'b1;
    step(QUAL);
    chk("R2 valid again", srcSel, 1);

    // power cycle with opposite straps
    supplyGood = 1'b0;
    step(1);
    chk("R10 src after drop", srcSel, 0);
    chk("R10 range after drop", rangeHigh, 0);
    rtValid = 1'b0; rtShort = 1'b1; oscStrap = 1'b0;
    ditherRail = 1'b1; ditherLive = 1'b1;
    supplyGood = 1'b1;
    step(1);
    rtShort = 1'b0; rtValid = 1'b1; oscStrap = 1'b1;
    step(QUAL + 5);
    chk("R3 short at capture locks resistor", srcSel, 0);
    chk("R1 range latched low", rangeHigh, 0);
    chk("R7 dither locked by rail strap", ditherEn, 0);
    syncPresent = 1'b1;
    step(1);
    chk("R5 sync with locked resistor", srcSel, 2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule